// File: doc/BRIEF.md
# BT.656 Timing-Reference Embedder and Word Multiplexer

This block turns 4:2:2 component video into a single 10-bit word stream at twice the pixel rate. The stream carries embedded timing-reference sequences. It runs on a line-locked clock at the double rate and consumes one word slot per clock. Alongside each slot it receives a luma sample, a chroma sample, a line-blanking flag, a frame-blanking flag, a field flag and an enable. Upstream presents Cb and Cr alternately on the chroma bus. The enable is the product of the two mode settings that select the multiplexed output.

The block emits an end-of-active-video sequence on the first blanked slot of each line. It emits a start-of-active-video sequence in the four slots just before the first active slot. Both sequences are four words long: all ones, zero, zero, and a protected flag word that carries field, frame-blanking and line-blanking state. The remaining blanking slots carry the neutral fill of 512 for chroma and 64 for luma, alternating. During active video the words alternate chroma, luma, chroma, luma. A four-slot look-ahead delay is what places the start sequence ahead of the first active slot. Every word therefore leaves the block four clocks after its slot is sampled.

Top module: `bt656_trs_mux`

## Requirements
- R1: While reset is asserted, and on leaving it, `data_o` is 0 and `valid_o` is 0.
- R2: A slot sampled with `en_i` low produces `valid_o` = 0 and `data_o` = 0.
- R3: A slot whose `hblank_i` is 1 while the previous slot's was 0 starts the end sequence. That slot and the next three carry 0x3FF, 0x000, 0x000 and then the flag word with H = 1.
- R4: When slot n+4 has `hblank_i` = 0 and slot n+3 has it at 1, slots n to n+3 carry 0x3FF, 0x000, 0x000 and then the flag word with H = 0.
- R5: The flag word is laid out as follows. Bit 9 is 1, bit 8 is F, bit 7 is V and bit 6 is H. Bit 5 is V^H, bit 4 is F^H, bit 3 is F^V and bit 2 is F^V^H. Bits 1:0 are 0.
- R6: F and V are taken from `field_i` and `vblank_i` of the slot where a sequence starts. They keep those values for its four words, even if the inputs change.
- R7: A blanked slot that is outside a sequence carries 512 on the chroma phase and 64 on the luma phase. The phases alternate every slot, and the slot after a sequence is on the chroma phase.
- R8: An active slot outside a sequence carries `chroma_i` on the chroma phase and `luma_i` on the luma phase. The phases alternate every slot.
- R9: No sequence starts while one is in progress. When both sequences are due in the same slot, the end sequence wins.
- R10: A slot with `en_i` low abandons any sequence in progress. The next enabled slot is on the chroma phase.
- R11: The word for a slot sampled at clock edge k appears on `data_o`/`valid_o` after edge k+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line-locked clock at twice the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Multiplexed-output mode enable for this slot |
| hblank_i | input | 1 | Line blanking for this slot |
| vblank_i | input | 1 | Frame blanking for this slot |
| field_i | input | 1 | Field flag for this slot |
| luma_i | input | 10 | Luma sample |
| chroma_i | input | 10 | Chroma sample, Cb and Cr alternating |
| data_o | output | 10 | Multiplexed output word |
| valid_o | output | 1 | Output word strobe |

## Verification
The assertions check several properties on every clock:
- disabled slots read as zero;
- the strobe trails the enable by the fixed latency;
- an all-ones header word is followed by a zero word unless the enable drops;
- each flag word carries consistent protection bits;
- blanking fill stays on its two levels and alternates.

Other behaviour depends on the surrounding input history, and only the bench's scenarios can show it. This covers where sequences fall relative to the blanking edges, which F and V values they hold, and the priority and suppression rules for short blanking intervals. It also covers the phase restart after a sequence or an enable drop.

// File: rtl/bt656_pkg.sv
`timescale 1ns/1ps
package bt656_pkg;

    parameter int unsigned WORD_W = 10;
    localparam int unsigned TRS_LEN = 4;
    localparam int unsigned IDX_W = $clog2(TRS_LEN);
    localparam int unsigned FLAG_BITS = 8;

    localparam logic [WORD_W-1:0] FILL_C = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] FILL_Y = {3'b000, 1'b1, {(WORD_W-4){1'b0}}};

    // one word slot as sampled at the input
    typedef struct packed {
        logic              en;
        logic              hblk;
        logic              vblk;
        logic              fld;
        logic [WORD_W-1:0] y;
        logic [WORD_W-1:0] c;
    } slot_t;

    // what the output word is made of
    typedef enum logic [2:0] {
        K_OFF, K_ONES, K_ZERO, K_XY, K_FILL_C, K_FILL_Y, K_CHROMA, K_LUMA
    } kind_e;

    typedef struct packed {
        logic             act;
        logic [IDX_W-1:0] idx;
        logic             h;
        logic             f;
        logic             v;
        logic             ph;
    } seq_t;

    typedef struct packed {
        logic              valid;
        kind_e             kind;
        logic [WORD_W-1:0] data;
    } out_t;

    function automatic logic [WORD_W-1:0] xy_word(input logic f, input logic v, input logic h);
        logic [FLAG_BITS-1:0] b;
        logic [WORD_W-1:0]    w;
        b = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
        w = '0;
        w[WORD_W-1 -: FLAG_BITS] = b;
        return w;
    endfunction

endpackage

// File: rtl/bt656_slot_delay.sv
`timescale 1ns/1ps
module bt656_slot_delay
    import bt656_pkg::*;
#(
    parameter int unsigned DEPTH = 5
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  slot_t slot_i,
    output slot_t tap_o [DEPTH]
);

    slot_t stage_d [DEPTH];
    slot_t stage_q [DEPTH];

    always_comb begin
        stage_d[0] = slot_i;
        for (int i = 1; i < DEPTH; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= stage_d[i];
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        assign tap_o[g] = stage_q[g];
    end

endmodule

// File: rtl/bt656_trs_seq.sv
`timescale 1ns/1ps
module bt656_trs_seq
    import bt656_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  slot_t cur_i,
    input  logic  prev_hblk_i,
    input  logic  last_blank_i,
    input  logic  first_active_i,
    output kind_e kind_o,
    output logic  f_o,
    output logic  v_o,
    output logic  h_o
);

    seq_t s_d, s_q;
    logic start_eav, start_sav;
    logic [IDX_W-1:0] idx;

    assign start_eav = cur_i.en & cur_i.hblk & ~prev_hblk_i;
    assign start_sav = cur_i.en & last_blank_i & ~first_active_i;

    always_comb begin
        s_d    = s_q;
        kind_o = K_OFF;
        f_o    = s_q.f;
        v_o    = s_q.v;
        h_o    = s_q.h;
        idx    = s_q.idx;
        if (!cur_i.en) begin
            s_d.act = 1'b0;
            s_d.idx = '0;
            s_d.ph  = 1'b0;
        end else if (s_q.act || start_eav || start_sav) begin
            if (!s_q.act) begin
                idx     = '0;
                s_d.h   = start_eav;
                s_d.f   = cur_i.fld;
                s_d.v   = cur_i.vblk;
                h_o     = start_eav;
                f_o     = cur_i.fld;
                v_o     = cur_i.vblk;
            end
            if (idx == '0)                        kind_o = K_ONES;
            else if (idx == IDX_W'(TRS_LEN - 1))  kind_o = K_XY;
            else                                  kind_o = K_ZERO;
            s_d.idx = idx + 1'b1;
            s_d.act = (idx != IDX_W'(TRS_LEN - 1));
            s_d.ph  = (idx == IDX_W'(TRS_LEN - 1)) ? 1'b0 : ~s_q.ph;
        end else begin
            if (cur_i.hblk) kind_o = s_q.ph ? K_FILL_Y : K_FILL_C;
            else            kind_o = s_q.ph ? K_LUMA : K_CHROMA;
            s_d.ph = ~s_q.ph;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

endmodule

// File: rtl/bt656_trs_mux.sv
`timescale 1ns/1ps
module bt656_trs_mux
    import bt656_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              hblank_i,
    input  logic              vblank_i,
    input  logic              field_i,
    input  logic [WORD_W-1:0] luma_i,
    input  logic [WORD_W-1:0] chroma_i,
    output logic [WORD_W-1:0] data_o,
    output logic              valid_o
);

    localparam int unsigned LOOK  = TRS_LEN;
    localparam int unsigned DEPTH = LOOK + 1;

    slot_t in_slot;
    slot_t tap [DEPTH];
    slot_t cur;
    kind_e kind;
    logic  f, v, h;
    out_t  out_d, out_q;
    kind_e kind_q;

    assign in_slot = '{en: en_i, hblk: hblank_i, vblk: vblank_i, fld: field_i,
                       y: luma_i, c: chroma_i};

    bt656_slot_delay #(.DEPTH(DEPTH)) u_delay (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .slot_i (in_slot),
        .tap_o  (tap)
    );

    assign cur = tap[LOOK-1];

    bt656_trs_seq u_seq (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .cur_i          (cur),
        .prev_hblk_i    (tap[LOOK].hblk),
        .last_blank_i   (tap[0].hblk),
        .first_active_i (hblank_i),
        .kind_o         (kind),
        .f_o            (f),
        .v_o            (v),
        .h_o            (h)
    );

    always_comb begin
        out_d.valid = cur.en;
        out_d.kind  = kind;
        case (kind)
            K_ONES:   out_d.data = '1;
            K_XY:     out_d.data = xy_word(f, v, h);
            K_FILL_C: out_d.data = FILL_C;
            K_FILL_Y: out_d.data = FILL_Y;
            K_CHROMA: out_d.data = cur.c;
            K_LUMA:   out_d.data = cur.y;
            default:  out_d.data = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign data_o  = out_q.data;
    assign valid_o = out_q.valid;
    assign kind_q  = out_q.kind;

endmodule

// File: rtl/bt656_trs_mux_chk.sv
`timescale 1ns/1ps
module bt656_trs_mux_chk
    import bt656_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic [WORD_W-1:0] data_o,
    input logic              valid_o,
    input kind_e             kind_i
);

    localparam int unsigned SEEN = TRS_LEN + 1;

    logic [3:0] age_q;
    logic       is_fill;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                age_q <= '0;
        else if (age_q < 4'(SEEN))  age_q <= age_q + 1'b1;
    end

    assign is_fill = valid_o && (kind_i == K_FILL_C || kind_i == K_FILL_Y);

    AST_OFF_IS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> data_o == '0); // R2

    AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 4'(SEEN)) |-> valid_o == $past(en_i, 5)); // R11

    AST_ONES_THEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && data_o == '1 && kind_i == K_ONES) |=> (!valid_o || data_o == '0)); // R3

    AST_XY_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && kind_i == K_XY) |->
            (data_o[WORD_W-1]
             && data_o[WORD_W-5] == (data_o[WORD_W-3] ^ data_o[WORD_W-4])
             && data_o[WORD_W-6] == (data_o[WORD_W-2] ^ data_o[WORD_W-4])
             && data_o[WORD_W-7] == (data_o[WORD_W-2] ^ data_o[WORD_W-3])
             && data_o[WORD_W-8] == (data_o[WORD_W-2] ^ data_o[WORD_W-3] ^ data_o[WORD_W-4]))); // R5

    AST_FILL_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_fill |-> (data_o == FILL_C || data_o == FILL_Y)); // R7

    AST_FILL_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_fill && $past(is_fill)) |-> data_o != $past(data_o)); // R7

endmodule

bind bt656_trs_mux bt656_trs_mux_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .data_o  (data_o),
    .valid_o (valid_o),
    .kind_i  (kind_q)
);

// File: tb/bt656_trs_mux_bench.sv
`timescale 1ns/1ps
module bt656_trs_mux_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, hb = 1'b0, vb = 1'b0, fl = 1'b0;
    logic [9:0] luma = '0, chroma = '0;
    logic [9:0] data_o;
    logic       valid_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string scen = "R2 startup";

    always #2.5 clk = ~clk;

    bt656_trs_mux u_bt656_trs_mux (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .hblank_i(hb), .vblank_i(vb),
        .field_i(fl), .luma_i(luma), .chroma_i(chroma), .data_o(data_o), .valid_o(valid_o)
    );

    typedef struct { bit en, h, v, f; int y, c; } slot_s;
    slot_s hist[$];

    int m_act = 0, m_idx = 0, m_ph = 0;
    bit m_h = 0, m_f = 0, m_v = 0;

    function automatic slot_s get(int i);
        slot_s z = '{0, 0, 0, 0, 0, 0};
        if (i < 0 || i >= hist.size()) return z;
        return hist[i];
    endfunction

    function automatic int flag_word(bit f, bit v, bit h);
        return 512 + f*256 + v*128 + h*64 + (v^h)*32 + (f^h)*16 + (f^v)*8 + (f^v^h)*4;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, scen, act, exp);
        end
    endtask

    task automatic model_step(int n, output int ed, output bit ev, output string tag);
        slot_s c, p, a3, a4;
        bit se, ss;
        c = get(n); p = get(n-1); a3 = get(n+3); a4 = get(n+4);
        se = c.en && c.h && !p.h;
        ss = c.en && a3.h && !a4.h;
        if (!c.en) begin
            ed = 0; ev = 0; tag = "R2";
            m_act = 0; m_idx = 0; m_ph = 0;
        end else begin
            ev = 1;
            if (m_act == 0 && (se || ss)) begin
                m_act = 1; m_idx = 0; m_h = se; m_f = c.f; m_v = c.v;
            end
            if (m_act != 0) begin
                tag = m_h ? "R3" : "R4";
                if (m_idx == 0) ed = 1023;
                else if (m_idx == 3) begin ed = flag_word(m_f, m_v, m_h); tag = "R5"; end
                else ed = 0;
                if (m_idx == 3) begin m_act = 0; m_ph = 0; end
                else begin m_idx++; m_ph ^= 1; end
            end else if (c.h) begin
                ed = m_ph ? 64 : 512; tag = "R7"; m_ph ^= 1;
            end else begin
                ed = m_ph ? c.y : c.c; tag = "R8"; m_ph ^= 1;
            end
        end
    endtask

    // one slot: record what the design samples, then compare after the edge
    task automatic tick();
        slot_s s;
        int ed; bit ev; string tag;
        s.en = en; s.h = hb; s.v = vb; s.f = fl; s.y = luma; s.c = chroma;
        hist.push_back(s);
        @(posedge clk);
        @(negedge clk);
        model_step(hist.size() - 1 - 4, ed, ev, tag);
        check("R11 valid", int'(valid_o), int'(ev));
        check(tag, int'(data_o), ed);
    endtask

    task automatic put(bit e, bit h, bit v, bit f, int cnt);
        for (int i = 0; i < cnt; i++) begin
            en = e; hb = h; vb = v; fl = f;
            luma = 10'($urandom_range(1000, 16));
            chroma = 10'($urandom_range(1000, 16));
            tick();
        end
    endtask

    task automatic line(int blank, int active, bit v, bit f);
        put(1, 1, v, f, blank);
        put(1, 0, v, f, active);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 data", int'(data_o), 0);
        check("R1 valid", int'(valid_o), 0);
        rst_n = 1'b1;
        check("R1 data after release", int'(data_o), 0);
        check("R1 valid after release", int'(valid_o), 0);

        scen = "R2 disabled";
        put(0, 1, 0, 0, 3);
        put(0, 0, 0, 0, 4);

        scen = "R3 R4 R7 R8 normal lines";
        put(1, 0, 0, 0, 6);
        line(12, 16, 0, 0);
        line(12, 16, 0, 0);
        line(10, 12, 1, 0);
        line(10, 12, 1, 1);
        line(9, 13, 0, 1);

        scen = "R6 flags held";
        put(1, 1, 0, 0, 1);
        put(1, 1, 1, 1, 6);
        put(1, 1, 0, 0, 3);
        put(1, 0, 1, 0, 10);

        scen = "R9 short blanking";
        line(5, 10, 0, 0);
        line(4, 10, 1, 0);
        line(2, 10, 0, 1);
        line(8, 10, 0, 0);

        scen = "R10 enable drop";
        put(1, 0, 0, 0, 6);
        put(1, 1, 0, 0, 2);
        put(0, 1, 0, 0, 3);
        put(1, 1, 0, 0, 9);
        put(1, 0, 0, 0, 7);
        put(0, 0, 0, 0, 2);
        put(1, 0, 0, 0, 9);
        put(1, 1, 1, 1, 5);
        put(1, 1, 1, 1, 1);
        put(0, 1, 1, 1, 1);
        put(1, 0, 1, 1, 8);

        scen = "R11 flush";
        line(12, 8, 0, 0);
        put(0, 0, 0, 0, 6);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule